// File: doc/BRIEF.md
# Performance Event Counter Unit

This block counts hardware events for software that wants to profile a processor or fabric. It has a parameterized number of 32-bit general-purpose counters and one 64-bit cycle counter, all reached through a small word-wide register port. Software picks a counter with a selector register. It then reads or writes that counter's value and event type through two indirect registers, and controls the whole set with bitmask registers for enabling, interrupts and overflow status.

Each clock, a vector of event lines delivers small unsigned increments. Event line k carries event number k+1. A general-purpose counter programmed with event number e adds the delta present on line e-1. Event number 0 is reserved for software increments. An overflow sets a sticky status bit, and a level interrupt is raised while any status bit is set together with its interrupt-enable bit.

The register port is a single-cycle write strobe with address and data. Read data is combinational from the address. Register addresses: 0 control, 1 selector, 2 selected value low word, 3 selected value high word, 4 selected event type, 5 count enable, 6 interrupt enable, 7 overflow status, 8 software increment.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset all counters, event types, the selector, count enable, interrupt enable and overflow status are zero, the interrupt output is low and the control word reads only its constant fields.
- R2: Control word bit 0 (run), bit 3 (cycle prescaler) and bit 6 (long cycle overflow) are stored and read back. Bits 15:11 always read NUM_CTRS, bits 23:16 read ID_CODE and bits 31:24 read IMPL_CODE regardless of writes. Bits 1 and 2 always read zero.
- R3: A general-purpose counter programmed with event number e (1 to NUM_LINES) adds the delta on event line e-1 on every clock where control bit 0 and its own count-enable bit are both set. Otherwise it holds.
- R4: The selector register keeps bits 4:0 of a write. The event-type register at address 4 keeps bits 9:0 of a write for the selected general-purpose counter.
- R5: Writing the software-increment register adds one to counter n for each set bit n, but only where counter n is enabled (control bit 0 and count-enable bit n) and programmed with event 0.
- R6: Writing control bit 1 as one clears every general-purpose counter and leaves the cycle counter unchanged. Writing control bit 2 as one clears only the cycle counter and its prescaler remainder.
- R7: Index 31 selects the cycle counter, which advances by one per clock while control bit 0 and count-enable bit 31 are set. With control bit 3 set, it advances once per 64 such clocks.
- R8: General-purpose counters are 32 bits wide and read zero in the high word. A carry out of bit 31 wraps the counter and sets overflow status bit n.
- R9: The cycle counter sets overflow status bit 31 on a carry out of bit 31 when control bit 6 is clear, and only on a carry out of bit 63 when it is set. The full 64-bit value keeps counting in both modes.
- R10: Writing one to an overflow status bit clears it. The interrupt output is high exactly when some status bit and its matching interrupt-enable bit are both set.
- R11: For a selector value that names no counter (NUM_CTRS to 30), value and event-type reads return zero and writes are ignored. The event type of index 31 reads zero. Mask bits of absent counters read zero.
- R12: A write to the value low word loads the selected counter. For index 31, the high word loads the upper half of the cycle counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| evt_delta | input | NUM_LINES*DELTA_W | Per-line event increments, line k in bits k*DELTA_W upward |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The bench builds the unit with four general-purpose counters, four event lines and 3-bit deltas. With these values, selector indices 4 to 30 name absent counters and a control read has a known counter-count field. Preloading values near the 32-bit and 64-bit limits makes each overflow reachable in one counting clock. The prescaler gives a small exact count over 130 clocks, and a mix of enabled and disabled counters shows that enables and event routing are honoured.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

    localparam int REG_AW     = 4;
    localparam int DATA_W     = 32;
    localparam int EVT_W      = 10;
    localparam int CYC_IDX    = 31;
    localparam int PRESCALE_W = 6;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL   = 4'd0,
        RA_SEL    = 4'd1,
        RA_VAL_LO = 4'd2,
        RA_VAL_HI = 4'd3,
        RA_TYPE   = 4'd4,
        RA_CNT_EN = 4'd5,
        RA_INT_EN = 4'd6,
        RA_OVF    = 4'd7,
        RA_SW_INC = 4'd8
    } reg_addr_e;

    // stored control bits
    typedef struct packed {
        logic long_cyc;
        logic cyc_div;
        logic run;
    } ctrl_t;

    // bitmask of implemented counter indices: 0..n-1 plus the cycle counter
    function automatic logic [DATA_W-1:0] impl_mask(input int n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n || i == CYC_IDX) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c, input int n,
                                                    input logic [7:0] id,
                                                    input logic [7:0] impl);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = c.run;
        w[3]     = c.cyc_div;
        w[6]     = c.long_cyc;
        w[15:11] = 5'(n);
        w[23:16] = id;
        w[31:24] = impl;
        return w;
    endfunction

endpackage

// File: rtl/perf_event_ctr.sv
module perf_event_ctr
    import perf_mon_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int DELTA_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cnt_en,
    input  logic [NUM_LINES*DELTA_W-1:0] evt_delta,
    input  logic                         sw_inc,
    input  logic                         clr,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         typ_we,
    input  logic [EVT_W-1:0]             typ_wdata,
    output logic [DATA_W-1:0]            value,
    output logic [EVT_W-1:0]             evt_type,
    output logic                         ovf_pulse
);

    localparam int INC_W = DELTA_W + 1;

    logic [DATA_W-1:0] val_q;
    logic [EVT_W-1:0]  evt_q;
    logic [INC_W-1:0]  inc;
    logic [DATA_W:0]   sum;

    always_comb begin
        inc = '0;
        if (evt_q == '0) begin
            inc = INC_W'(sw_inc);
        end else begin
            for (int k = 0; k < NUM_LINES; k++) begin
                if (evt_q == EVT_W'(k + 1))
                    inc = {1'b0, evt_delta[k*DELTA_W +: DELTA_W]};
            end
        end
    end

    assign sum       = {1'b0, val_q} + (DATA_W+1)'(inc);
    assign ovf_pulse = cnt_en && !wr_en && !clr && sum[DATA_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
            evt_q <= '0;
        end else begin
            if (typ_we) evt_q <= typ_wdata;
            if (clr)         val_q <= '0;
            else if (wr_en)  val_q <= wr_data;
            else if (cnt_en) val_q <= sum[DATA_W-1:0];
        end
    end

    assign value    = val_q;
    assign evt_type = evt_q;

endmodule

// File: rtl/perf_cycle_ctr.sv
module perf_cycle_ctr
    import perf_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              div_en,
    input  logic              long_mode,
    input  logic              clr,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output logic [63:0]       value,
    output logic              ovf_pulse
);

    logic [63:0]           val_q;
    logic [PRESCALE_W-1:0] rem_q;
    logic                  step;
    logic                  at_limit;

    assign step      = cnt_en && (!div_en || (&rem_q));
    assign at_limit  = long_mode ? (&val_q) : (&val_q[31:0]);
    assign ovf_pulse = step && at_limit && !clr && !wr_lo && !wr_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
            rem_q <= '0;
        end else begin
            if (clr)                  rem_q <= '0;
            else if (cnt_en && div_en) rem_q <= rem_q + 1'b1;

            if (clr)        val_q <= '0;
            else if (wr_lo) val_q[31:0]  <= wr_data;
            else if (wr_hi) val_q[63:32] <= wr_data;
            else if (step)  val_q <= val_q + 64'd1;
        end
    end

    assign value = val_q;

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import perf_mon_pkg::*;
#(
    parameter int         NUM_CTRS  = 6,
    parameter int         NUM_LINES = 8,
    parameter int         DELTA_W   = 4,
    parameter logic [7:0] ID_CODE   = 8'h21,
    parameter logic [7:0] IMPL_CODE = 8'h7E
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_we,
    input  logic [3:0]                   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic [NUM_LINES*DELTA_W-1:0] evt_delta,
    output logic                         irq_o
);

    localparam logic [DATA_W-1:0] MASK = impl_mask(NUM_CTRS);

    ctrl_t             ctrl_q;
    logic [4:0]        sel_q;
    logic [DATA_W-1:0] cnten_q, inten_q, ovf_q;
    logic              run;

    logic wr_ctrl, wr_sel, wr_vlo, wr_vhi, wr_type, wr_cnten, wr_inten, wr_ovf, wr_swinc;
    logic sel_cyc;

    logic [DATA_W-1:0] ctr_val  [NUM_CTRS];
    logic [EVT_W-1:0]  ctr_type [NUM_CTRS];
    logic [DATA_W-1:0] ovf_set;
    logic [63:0]       cyc_val;
    logic              cyc_ovf;

    assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
    assign wr_sel   = reg_we && (reg_addr == RA_SEL);
    assign wr_vlo   = reg_we && (reg_addr == RA_VAL_LO);
    assign wr_vhi   = reg_we && (reg_addr == RA_VAL_HI);
    assign wr_type  = reg_we && (reg_addr == RA_TYPE);
    assign wr_cnten = reg_we && (reg_addr == RA_CNT_EN);
    assign wr_inten = reg_we && (reg_addr == RA_INT_EN);
    assign wr_ovf   = reg_we && (reg_addr == RA_OVF);
    assign wr_swinc = reg_we && (reg_addr == RA_SW_INC);

    assign run     = ctrl_q.run;
    assign sel_cyc = (sel_q == 5'(CYC_IDX));

    always_comb begin
        ovf_set = '0;
        for (int i = 0; i < NUM_CTRS; i++) ovf_set[i] = ctr_ovf[i];
        ovf_set[CYC_IDX] = cyc_ovf;
    end

    logic [NUM_CTRS-1:0] ctr_ovf;

    generate
        for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
            perf_event_ctr #(
                .NUM_LINES (NUM_LINES),
                .DELTA_W   (DELTA_W)
            ) u_ctr (
                .clk       (clk),
                .rst       (rst),
                .cnt_en    (run && cnten_q[g]),
                .evt_delta (evt_delta),
                .sw_inc    (wr_swinc && reg_wdata[g]),
                .clr       (wr_ctrl && reg_wdata[1]),
                .wr_en     (wr_vlo && (sel_q == 5'(g))),
                .wr_data   (reg_wdata),
                .typ_we    (wr_type && (sel_q == 5'(g))),
                .typ_wdata (reg_wdata[EVT_W-1:0]),
                .value     (ctr_val[g]),
                .evt_type  (ctr_type[g]),
                .ovf_pulse (ctr_ovf[g])
            );
        end
    endgenerate

    perf_cycle_ctr u_cyc (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (run && cnten_q[CYC_IDX]),
        .div_en    (ctrl_q.cyc_div),
        .long_mode (ctrl_q.long_cyc),
        .clr       (wr_ctrl && reg_wdata[2]),
        .wr_lo     (wr_vlo && sel_cyc),
        .wr_hi     (wr_vhi && sel_cyc),
        .wr_data   (reg_wdata),
        .value     (cyc_val),
        .ovf_pulse (cyc_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            sel_q   <= '0;
            cnten_q <= '0;
            inten_q <= '0;
            ovf_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run      <= reg_wdata[0];
                ctrl_q.cyc_div  <= reg_wdata[3];
                ctrl_q.long_cyc <= reg_wdata[6];
            end
            if (wr_sel)   sel_q   <= reg_wdata[4:0];
            if (wr_cnten) cnten_q <= reg_wdata & MASK;
            if (wr_inten) inten_q <= reg_wdata & MASK;
            ovf_q <= (ovf_q & ~((wr_ovf ? reg_wdata : '0) & MASK)) | ovf_set;
        end
    end

    assign irq_o = |(ovf_q & inten_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:   reg_rdata = ctrl_word(ctrl_q, NUM_CTRS, ID_CODE, IMPL_CODE);
            RA_SEL:    reg_rdata = {27'd0, sel_q};
            RA_VAL_LO: begin
                if (sel_cyc) reg_rdata = cyc_val[31:0];
                for (int i = 0; i < NUM_CTRS; i++)
                    if (sel_q == 5'(i)) reg_rdata = ctr_val[i];
            end
            RA_VAL_HI: if (sel_cyc) reg_rdata = cyc_val[63:32];
            RA_TYPE: begin
                for (int i = 0; i < NUM_CTRS; i++)
                    if (sel_q == 5'(i)) reg_rdata = {{(DATA_W-EVT_W){1'b0}}, ctr_type[i]};
            end
            RA_CNT_EN: reg_rdata = cnten_q;
            RA_INT_EN: reg_rdata = inten_q;
            RA_OVF:    reg_rdata = ovf_q;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/perf_mon_unit_chk.sv
module perf_mon_unit_chk
    import perf_mon_pkg::*;
#(
    parameter int NUM_CTRS = 6
) (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [3:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        irq_o,
    input logic [31:0] ovf_q,
    input logic [4:0]  sel_q,
    input logic [63:0] cyc_val,
    input logic        run_q
);

    logic [31:0] w1c_mask;
    logic        cyc_touch;

    assign w1c_mask  = (reg_we && reg_addr == RA_OVF) ? reg_wdata : 32'd0;
    assign cyc_touch = reg_we && (reg_addr == RA_CTRL || reg_addr == RA_VAL_LO ||
                                  reg_addr == RA_VAL_HI);

    // R2: constant fields of the control word
    p_ctrl_const_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_CTRL) |-> (reg_rdata[15:11] == 5'(NUM_CTRS) && reg_rdata[2:1] == 2'b00));

    // R11: absent counter indices read zero
    p_absent_zero_r11: assert property (@(posedge clk) disable iff (rst)
        ((reg_addr == RA_VAL_LO || reg_addr == RA_TYPE || reg_addr == RA_VAL_HI) &&
         int'(sel_q) >= NUM_CTRS && sel_q != 5'(CYC_IDX)) |-> (reg_rdata == 32'd0));

    // R7: the cycle counter holds while counting is stopped and nothing writes it
    p_cyc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cyc_touch) |=> $stable(cyc_val));

    // R10: status bits are sticky until cleared by a write of one
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(ovf_q) & ~$past(w1c_mask)) & ~ovf_q) == 32'd0));

    // R10: the interrupt only stands on a pending overflow
    p_irq_needs_ovf_r10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ovf_q != 32'd0));

endmodule

bind perf_mon_unit perf_mon_unit_chk #(.NUM_CTRS(NUM_CTRS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .ovf_q     (ovf_q),
    .sel_q     (sel_q),
    .cyc_val   (cyc_val),
    .run_q     (run)
);

// File: tb/perf_mon_unit_bench.sv
`timescale 1ns/1ps
module perf_mon_unit_bench;

    localparam int NC = 4;
    localparam int NL = 4;
    localparam int DW = 3;

    localparam logic [3:0] A_CTRL = 4'd0, A_SEL = 4'd1, A_VLO = 4'd2, A_VHI = 4'd3,
                           A_TYPE = 4'd4, A_CEN = 4'd5, A_IEN = 4'd6, A_OVF = 4'd7,
                           A_SWI = 4'd8;
    localparam logic [31:0] CTRL_CONST = 32'hC35A_2000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_we = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NL*DW-1:0]  evt_delta = '0;
    logic              irq_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    perf_mon_unit #(
        .NUM_CTRS (NC), .NUM_LINES (NL), .DELTA_W (DW),
        .ID_CODE (8'h5A), .IMPL_CODE (8'hC3)
    ) u_perf_mon_unit (
        .clk (clk), .rst (rst), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .evt_delta (evt_delta),
        .irq_o (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic pulse_events(input logic [NL*DW-1:0] d, input int n);
        evt_delta = d;
        repeat (n) @(negedge clk);
        evt_delta = '0;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", A_CTRL, CTRL_CONST);
        rd_chk("R1 cnten", A_CEN, 32'd0);
        rd_chk("R1 ovf", A_OVF, 32'd0);
        rd_chk("R1 value", A_VLO, 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_ctrl;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl all ones", A_CTRL, CTRL_CONST | 32'h49);
        wr(A_CTRL, 32'h0);
        rd_chk("R2 ctrl zero", A_CTRL, CTRL_CONST);
    endtask

    task automatic t_sel_type;
        wr(A_SEL, 32'hFFFF_FFE1);
        rd_chk("R4 selector", A_SEL, 32'd1);
        wr(A_TYPE, 32'hFFFF_F402);
        rd_chk("R4 type", A_TYPE, 32'h002);
    endtask

    task automatic t_count;
        wr(A_SEL, 0); wr(A_TYPE, 1);
        wr(A_SEL, 1); wr(A_TYPE, 2);
        wr(A_CEN, 32'h1);
        wr(A_CTRL, 32'h1);
        pulse_events({3'd0, 3'd0, 3'd5, 3'd3}, 5);
        wr(A_CTRL, 32'h0);
        pulse_events({3'd0, 3'd0, 3'd0, 3'd7}, 3);
        wr(A_SEL, 0);
        rd_chk("R3 counter0 routed sum", A_VLO, 32'd15);
        rd_chk("R8 high word zero", A_VHI, 32'd0);
        wr(A_SEL, 1);
        rd_chk("R3 disabled counter1", A_VLO, 32'd0);
    endtask

    task automatic t_value_write;
        wr(A_VLO, 32'h1234_5678);
        rd_chk("R12 load", A_VLO, 32'h1234_5678);
    endtask

    task automatic t_swinc;
        wr(A_SEL, 3); wr(A_TYPE, 0);
        wr(A_CEN, 32'h9);
        wr(A_CTRL, 32'h1);
        wr(A_SWI, 32'hB);
        wr(A_CTRL, 32'h0);
        rd_chk("R5 sw event counter3", A_VLO, 32'd1);
        wr(A_SEL, 0);
        rd_chk("R5 non-sw counter0", A_VLO, 32'd15);
        wr(A_SEL, 1);
        rd_chk("R5 disabled counter1", A_VLO, 32'h1234_5678);
    endtask

    task automatic t_clear;
        wr(A_SEL, 31); wr(A_VLO, 32'd100);
        wr(A_CTRL, 32'h2);
        rd_chk("R6 cycle kept", A_VLO, 32'd100);
        wr(A_SEL, 0);
        rd_chk("R6 counter0 cleared", A_VLO, 32'd0);
        wr(A_SEL, 1);
        rd_chk("R6 counter1 cleared", A_VLO, 32'd0);
        wr(A_VLO, 32'd9);
        wr(A_CTRL, 32'h4);
        rd_chk("R6 counter1 kept", A_VLO, 32'd9);
        wr(A_SEL, 31);
        rd_chk("R6 cycle cleared", A_VLO, 32'd0);
    endtask

    task automatic t_cycle;
        wr(A_CEN, 32'h8000_0000);
        wr(A_CTRL, 32'h1);
        repeat (10) @(negedge clk);
        wr(A_CTRL, 32'h0);
        rd_chk("R7 cycle plain", A_VLO, 32'd11);
        wr(A_CTRL, 32'hD);
        repeat (129) @(negedge clk);
        wr(A_CTRL, 32'h0);
        rd_chk("R7 cycle prescaled", A_VLO, 32'd2);
    endtask

    task automatic t_cycle_ovf;
        wr(A_OVF, 32'hFFFF_FFFF);
        wr(A_VLO, 32'hFFFF_FFFF); wr(A_VHI, 32'h0);
        wr(A_CTRL, 32'h1); wr(A_CTRL, 32'h0);
        rd_chk("R9 short high", A_VHI, 32'd1);
        rd_chk("R9 short low", A_VLO, 32'd0);
        rd_chk("R9 short ovf", A_OVF, 32'h8000_0000);
        wr(A_OVF, 32'h8000_0000);
        rd_chk("R10 w1c", A_OVF, 32'd0);
        wr(A_VLO, 32'hFFFF_FFFF); wr(A_VHI, 32'h0);
        wr(A_CTRL, 32'h41); wr(A_CTRL, 32'h40);
        rd_chk("R9 long no ovf", A_OVF, 32'd0);
        rd_chk("R9 long high", A_VHI, 32'd1);
        wr(A_VLO, 32'hFFFF_FFFF); wr(A_VHI, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h41); wr(A_CTRL, 32'h0);
        rd_chk("R9 long wrap high", A_VHI, 32'd0);
        rd_chk("R9 long ovf", A_OVF, 32'h8000_0000);
        wr(A_OVF, 32'hFFFF_FFFF);
    endtask

    task automatic t_evt_ovf;
        wr(A_CEN, 32'h4);
        wr(A_SEL, 2); wr(A_TYPE, 3); wr(A_VLO, 32'hFFFF_FFFE);
        wr(A_CTRL, 32'h1);
        pulse_events({3'd0, 3'd3, 3'd0, 3'd0}, 1);
        wr(A_CTRL, 32'h0);
        rd_chk("R8 wrap value", A_VLO, 32'd1);
        rd_chk("R8 ovf bit", A_OVF, 32'h4);
        chk("R10 irq masked", {31'd0, irq_o}, 32'd0);
        wr(A_IEN, 32'h4);
        #1 chk("R10 irq raised", {31'd0, irq_o}, 32'd1);
        wr(A_OVF, 32'h4);
        #1 chk("R10 irq cleared", {31'd0, irq_o}, 32'd0);
        rd_chk("R10 ovf cleared", A_OVF, 32'd0);
    endtask

    task automatic t_absent;
        wr(A_SEL, 5);
        wr(A_VLO, 32'd123);
        wr(A_TYPE, 32'd7);
        rd_chk("R11 absent value", A_VLO, 32'd0);
        rd_chk("R11 absent type", A_TYPE, 32'd0);
        wr(A_SEL, 31);
        rd_chk("R11 cycle type", A_TYPE, 32'd0);
        wr(A_CEN, 32'hFFFF_FFFF);
        rd_chk("R11 mask bits", A_CEN, 32'h8000_000F);
        wr(A_CEN, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_sel_type();
        t_count();
        t_value_write();
        t_swinc();
        t_clear();
        t_cycle();
        t_cycle_ovf();
        t_evt_ovf();
        t_absent();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule